// File: doc/BRIEF.md
# BCD Alarm Comparator

This block watches the six fields of a running packed-BCD calendar (seconds, minutes, hours, day of month, month and two-digit year) and compares them with a set of programmed alarm bytes. Each field has its own match enable, so a field that is not enabled works as a wildcard. A separate global enable gates the whole comparison.

When every enabled field is equal to the calendar, the block latches a pending flag and drives a level interrupt. The flag is set once, on the clock where the comparison first becomes true. Software clears it by writing a one to its bit. All registers sit on a small byte-wide register bus with a write strobe, an address, write data and combinational readback. The calendar counter itself lives outside this block and supplies the current fields on plain input ports.

Top module: `rtc_alarm_match`

## Requirements
- R1: After synchronous reset, every register reads 0x00 and `irq` is low.
- R2: The alarm bytes for seconds, minutes, hours, day, month and year sit at addresses 1 to 6 in that order. A write stores the byte, and `rdata` returns the stored byte for the current `addr` in the same cycle.
- R3: The control register at address 0 uses bit 0 as the global enable and bits 1 to 6 as the field enables for seconds, minutes, hours, day, month and year. Bit 7 reads 0. A write replaces the whole register, so writing 0x00 clears every enable, and rewriting the value with only bit 0 changed leaves the field enables as they were.
- R4: When the global enable is set and every enabled field equals its calendar input, the pending flag is set on the next clock edge.
- R5: A field whose enable bit is clear matches any calendar value, including a different month or year.
- R6: With no field enable set, the pending flag is never set, even when the global enable is set.
- R7: The alarm is one-shot. The pending flag is set only on a false-to-true change of the full comparison, so a comparison that stays true does not set the flag again after it is cleared.
- R8: The pending register is at address 7, with the flag in bit 0. Writing a 1 to bit 0 clears the flag, and writing 0 leaves it unchanged. When a new match and a clear fall in the same cycle, the flag stays set.
- R9: `irq` is high exactly while the pending flag and the global enable are both set. Clearing the global enable masks `irq` but keeps the pending flag.
- R10: With the global enable clear, a full match of the enabled fields does not set the pending flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational readback of the register at `addr` |
| t_sec | input | 8 | Current seconds, BCD |
| t_min | input | 8 | Current minutes, BCD |
| t_hour | input | 8 | Current hours, BCD |
| t_day | input | 8 | Current day of month, BCD |
| t_mon | input | 8 | Current month 01 to 12, BCD |
| t_year | input | 8 | Current year 00 to 99, BCD |
| irq | output | 1 | Level alarm interrupt |

## Verification
A register write takes effect at the clock edge that samples the strobe. Readback is combinational, so the bench samples `rdata` shortly after it sets `addr`. A match that becomes true sets the pending flag at the following edge, so the bench writes the control byte last and checks pending and `irq` one further falling edge later. A write to control therefore shows its effect on pending two edges after the strobe is driven. The one-shot, same-cycle set-over-clear and masking cases line up the calendar inputs and the clear write on a single edge, and check after that edge and again several cycles later.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
    localparam int FIELD_W    = 8;
    localparam int NUM_FIELDS = 6;
    localparam int ADDR_W     = 4;
    localparam int CTRL_W     = NUM_FIELDS + 1;

    localparam logic [ADDR_W-1:0] ADR_CTRL = '0;
    localparam logic [ADDR_W-1:0] ADR_PEND = ADDR_W'(NUM_FIELDS + 1);

    // field index 0 = seconds ... 5 = year
    typedef logic [NUM_FIELDS-1:0][FIELD_W-1:0] cal_t;

    typedef struct packed {
        logic [NUM_FIELDS-1:0] fld_en;   // bits CTRL_W-1..1
        logic                  glb_en;   // bit 0
    } ctrl_t;

    function automatic logic fld_match(input logic en,
                                       input logic [FIELD_W-1:0] a,
                                       input logic [FIELD_W-1:0] b);
        return !en || (a == b);
    endfunction
endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
    import rtc_alarm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [FIELD_W-1:0] wdata,
    input  logic               pending,
    output ctrl_t              ctrl,
    output cal_t               alm,
    output logic               pend_clr,
    output logic [FIELD_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_en && addr == ADR_CTRL) begin
            ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
        end
    end

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_alm
        always_ff @(posedge clk) begin
            if (rst) begin
                alm[i] <= '0;
            end else if (wr_en && addr == ADDR_W'(i + 1)) begin
                alm[i] <= wdata;
            end
        end
    end

    assign pend_clr = wr_en && (addr == ADR_PEND) && wdata[0];

    always_comb begin
        rdata = '0;
        if (addr == ADR_CTRL) begin
            rdata = {{(FIELD_W-CTRL_W){1'b0}}, ctrl};
        end else if (addr == ADR_PEND) begin
            rdata = {{(FIELD_W-1){1'b0}}, pending};
        end
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (addr == ADDR_W'(i + 1)) begin
                rdata = alm[i];
            end
        end
    end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
    import rtc_alarm_pkg::*;
(
    input  ctrl_t ctrl,
    input  cal_t  alm,
    input  cal_t  cur,
    output logic  hit
);
    logic [NUM_FIELDS-1:0] ok;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_cmp
        assign ok[i] = fld_match(ctrl.fld_en[i], alm[i], cur[i]);
    end

    assign hit = ctrl.glb_en && (|ctrl.fld_en) && (&ok);
endmodule

// File: rtl/rtc_alarm_event.sv
module rtc_alarm_event (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic pend_clr,
    input  logic glb_en,
    output logic pending,
    output logic irq
);
    logic hit_q;
    logic fire;

    assign fire = hit && !hit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q   <= 1'b0;
            pending <= 1'b0;
        end else begin
            hit_q <= hit;
            if (fire) begin
                pending <= 1'b1;
            end else if (pend_clr) begin
                pending <= 1'b0;
            end
        end
    end

    assign irq = pending && glb_en;
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_alarm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [FIELD_W-1:0] wdata,
    output logic [FIELD_W-1:0] rdata,
    input  logic [FIELD_W-1:0] t_sec,
    input  logic [FIELD_W-1:0] t_min,
    input  logic [FIELD_W-1:0] t_hour,
    input  logic [FIELD_W-1:0] t_day,
    input  logic [FIELD_W-1:0] t_mon,
    input  logic [FIELD_W-1:0] t_year,
    output logic               irq
);
    ctrl_t ctrl;
    cal_t  alm;
    cal_t  cur;
    logic  pend_clr;
    logic  pending;
    logic  hit;

    assign cur = {t_year, t_mon, t_day, t_hour, t_min, t_sec};

    rtc_alarm_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .pending(pending), .ctrl(ctrl), .alm(alm), .pend_clr(pend_clr),
        .rdata(rdata)
    );

    rtc_alarm_cmp u_cmp (
        .ctrl(ctrl), .alm(alm), .cur(cur), .hit(hit)
    );

    rtc_alarm_event u_evt (
        .clk(clk), .rst(rst), .hit(hit), .pend_clr(pend_clr),
        .glb_en(ctrl.glb_en), .pending(pending), .irq(irq)
    );
endmodule

// File: rtl/rtc_alarm_match_chk.sv
module rtc_alarm_match_chk
    import rtc_alarm_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [FIELD_W-1:0] wdata,
    input logic [CTRL_W-1:0]  ctrl_bits,
    input logic               hit,
    input logic               pending,
    input logic               irq
);
    // R4: a rising comparison sets pending at the next edge
    assert_match_sets_R4: assert property (@(posedge clk) disable iff (rst)
        (hit && !$past(hit)) |=> pending);

    // R6 / R10: pending rises only if global and some field were enabled
    assert_needs_field_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(pending) |-> $past(ctrl_bits[CTRL_W-1:1] != '0));
    assert_needs_global_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(pending) |-> $past(ctrl_bits[0]));

    // R7: without a new rising comparison, a clear flag stays clear
    assert_one_shot_R7: assert property (@(posedge clk) disable iff (rst)
        (!pending && !(hit && !$past(hit))) |=> !pending);

    // R8: write-one clears when no new match arrives
    assert_w1c_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADR_PEND && wdata[0] && !(hit && !$past(hit))) |=> !pending);

    // R9: interrupt masked without global enable
    assert_irq_mask_R9: assert property (@(posedge clk) disable iff (rst)
        !ctrl_bits[0] |-> !irq);

    // R3: control write replaces the whole register
    assert_ctrl_write_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADR_CTRL) |=> ctrl_bits == $past(wdata[CTRL_W-1:0]));
endmodule

bind rtc_alarm_match rtc_alarm_match_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ctrl_bits(ctrl), .hit(hit), .pending(pending), .irq(irq)
);

// File: tb/rtc_alarm_match_bench.sv
module rtc_alarm_match_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] t_sec = '0, t_min = '0, t_hour = '0, t_day = '0, t_mon = '0, t_year = '0;
    logic       irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_alarm_match u_rtc_alarm_match (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .t_sec(t_sec), .t_min(t_min), .t_hour(t_hour),
        .t_day(t_day), .t_mon(t_mon), .t_year(t_year), .irq(irq)
    );

    // calendar/alarm packing: {year, mon, day, hour, min, sec}
    typedef struct packed {
        logic [7:0]  ctrl;
        logic [47:0] alm;
        logic [47:0] now;
        logic        exp;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'h7F, 48'h24_12_31_23_59_58, 48'h24_12_31_23_59_58, 1'b1}, // R4 full
        '{8'h7F, 48'h24_12_31_23_59_58, 48'h24_12_31_23_59_57, 1'b0}, // R4 miss
        '{8'h03, 48'h00_00_00_00_00_30, 48'h99_01_15_08_45_30, 1'b1}, // R5 sec
        '{8'h0D, 48'h00_00_00_08_45_00, 48'h99_01_15_08_45_11, 1'b1}, // R5 min+hour
        '{8'h0D, 48'h00_00_00_08_45_00, 48'h99_01_15_09_45_11, 1'b0}, // R5 miss
        '{8'h01, 48'h24_06_01_00_00_00, 48'h24_06_01_00_00_00, 1'b0}, // R6
        '{8'h7E, 48'h24_06_01_00_00_00, 48'h24_06_01_00_00_00, 1'b0}, // R10
        '{8'h61, 48'h24_06_00_00_00_00, 48'h24_06_17_13_02_44, 1'b1}  // R5 mon+year
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic set_time(input logic [47:0] t);
        {t_year, t_mon, t_day, t_hour, t_min, t_sec} = t;
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd(4'(a), v);
            check($sformatf("R1 reset reg %0d", a), v, 8'h00);
        end
        check("R1 reset irq", {7'b0, irq}, 8'h00);

        // R2: alarm byte readback
        for (int i = 0; i < 6; i++) wr(4'(i + 1), 8'h11 * 8'(i + 1));
        for (int i = 0; i < 6; i++) begin
            rd(4'(i + 1), v);
            check($sformatf("R2 alarm reg %0d", i + 1), v, 8'h11 * 8'(i + 1));
        end

        // R3: control layout and RMW
        wr(4'd0, 8'hFF);
        rd(4'd0, v); check("R3 bit7 reads 0", v, 8'h7F);
        wr(4'd0, 8'h7E);
        rd(4'd0, v); check("R3 global off keeps fields", v, 8'h7E);
        wr(4'd0, 8'h00);
        rd(4'd0, v); check("R3 zero clears all", v, 8'h00);

        // vector table
        for (int k = 0; k < NV; k++) begin
            wr(4'd0, 8'h00);
            wr(4'd7, 8'h01);
            for (int i = 0; i < 6; i++) wr(4'(i + 1), VECS[k].alm[i*8 +: 8]);
            set_time(VECS[k].now);
            wr(4'd0, VECS[k].ctrl);
            @(negedge clk);
            rd(4'd7, v);
            check($sformatf("R4/R5/R6/R10 vector %0d pending", k), v, {7'b0, VECS[k].exp});
            check($sformatf("R9 vector %0d irq", k), {7'b0, irq}, {7'b0, VECS[k].exp});
        end

        // one-shot R7: full match held, clear, stays clear
        wr(4'd0, 8'h00);
        wr(4'd7, 8'h01);
        for (int i = 0; i < 6; i++) wr(4'(i + 1), VECS[0].alm[i*8 +: 8]);
        set_time(VECS[0].now);
        wr(4'd0, 8'h7F);
        @(negedge clk);
        rd(4'd7, v); check("R4 pending set", v, 8'h01);
        wr(4'd7, 8'h00);
        rd(4'd7, v); check("R8 write zero no effect", v, 8'h01);
        wr(4'd7, 8'h01);
        repeat (4) @(negedge clk);
        rd(4'd7, v); check("R7 held match no refire", v, 8'h00);
        check("R7 irq low", {7'b0, irq}, 8'h00);

        // R9: masking by global enable keeps pending
        set_time(VECS[1].now);
        @(negedge clk);
        set_time(VECS[0].now);
        @(negedge clk);
        @(negedge clk);
        rd(4'd7, v); check("R4 refire after new edge", v, 8'h01);
        wr(4'd0, 8'h7E);
        rd(4'd7, v); check("R9 pending kept when masked", v, 8'h01);
        check("R9 irq masked", {7'b0, irq}, 8'h00);
        wr(4'd0, 8'h7F);
        check("R9 irq unmasked", {7'b0, irq}, 8'h01);

        // R8: set wins over simultaneous clear
        set_time(VECS[1].now);
        @(negedge clk);
        @(negedge clk);
        set_time(VECS[0].now);
        wr_en = 1'b1; addr = 4'd7; wdata = 8'h01;
        @(negedge clk);
        wr_en = 1'b0;
        rd(4'd7, v); check("R8 set beats clear", v, 8'h01);
        check("R9 irq after set", {7'b0, irq}, 8'h01);

        // R1: reset again clears all
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd(4'd0, v); check("R1 reset ctrl", v, 8'h00);
        rd(4'd7, v); check("R1 reset pending", v, 8'h00);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule